// File: doc/BRIEF.md
# Lockable Address Translation Cache

This block caches virtual-to-physical page translations in front of a hardware table walker. A lookup is compared against every cached translation at once. The registered result appears one cycle later. A hit returns the physical address, the access domain and the permission bits. A miss raises a walk request, and the walker's answer is installed in the cache. The requester then repeats the lookup to get the translation.

Entries come in two groups. The main array holds 32 general entries. When the array is full, a victim is chosen either round-robin or from a free-running 5-bit LFSR. A separate pinned area of four slots holds translations that software asks to keep. Pinning never uses up a main-array slot. Software cannot read or write entries directly. A pin command names a slot and a virtual address, and the block fetches the translation through the walker. Maintenance commands can:
- flush the main array;
- flush the pinned slots;
- drop every entry, in either group, that covers a given address;
- select the replacement policy.

Top module: `xlt_cache`

## Requirements
- R1: One cycle after an accepted lookup that hits, `lk_rsp_valid` and `lk_hit` are 1 and `lk_domain` and `lk_perm` show the entry's fields. For a 4 KB entry, `lk_pa` is {frame[19:0], va[11:0]}. For a 1 MB entry (`wk_rsp_big`=1), `lk_pa` is {frame[19:8], va[19:0]}.
- R2: When an accepted lookup misses, the next cycle shows `lk_rsp_valid`=1, `lk_hit`=0, `wk_req`=1, `busy`=1 and `wk_va` equal to the lookup address. `wk_req` and `wk_va` hold until `wk_rsp_valid`. While `busy` is 1, lookups and commands are ignored and produce no response.
- R3: A walk response with `busy`=1 installs the translation and clears `busy` in the next cycle. A main-array fill goes to the lowest-index invalid slot whenever one exists.
- R4: After reset, no entry is valid, `busy`, `wk_req` and `lk_rsp_valid` are 0, and the policy is pseudo-random.
- R5: In round-robin mode with a full main array, victims are taken in index order. The order starts at slot 0 after reset, and the pointer advances only on such evictions.
- R6: In pseudo-random mode with a full main array, the victim index comes from a 5-bit LFSR that advances every cycle. The new translation is resident right after the fill.
- R7: Command `mc_op`=3 walks `mc_va` and installs the result into pinned slot `mc_slot`. Hits from a pinned slot give `lk_locked`=1. All 32 main entries stay usable alongside the four pinned ones.
- R8: When a pinned entry and a main entry both cover the lookup address, the pinned entry's translation is returned.
- R9: Command `mc_op`=0 invalidates every main entry and leaves pinned entries valid.
- R10: Command `mc_op`=1 invalidates every pinned entry and leaves main entries valid.
- R11: Command `mc_op`=2 invalidates every main or pinned entry whose page (4 KB or 1 MB) contains `mc_va`, and no other entry.
- R12: Command `mc_op`=4 sets the policy from `mc_mode` (0 pseudo-random, 1 round-robin). A command accepted in the same cycle as a lookup wins, and the lookup is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_rsp_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_locked | output | 1 | Hit came from a pinned slot |
| lk_pa | output | 32 | Translated physical address |
| lk_domain | output | 4 | Access domain of the hit entry |
| lk_perm | output | 3 | Permission bits of the hit entry |
| busy | output | 1 | Waiting for a walk; inputs are ignored |
| wk_req | output | 1 | Walk request, held until response |
| wk_va | output | 32 | Address to walk |
| wk_rsp_valid | input | 1 | Walk response strobe |
| wk_rsp_big | input | 1 | 1 = 1 MB page, 0 = 4 KB page |
| wk_rsp_frame | input | 20 | Physical frame number (4 KB units) |
| wk_rsp_domain | input | 4 | Access domain |
| wk_rsp_perm | input | 3 | Permission bits |
| mc_valid | input | 1 | Maintenance command strobe |
| mc_op | input | 3 | 0 flush main, 1 flush pinned, 2 drop by address, 3 pin, 4 set policy |
| mc_va | input | 32 | Address for drop and pin |
| mc_slot | input | 2 | Pinned slot for a pin command |
| mc_mode | input | 1 | Policy for set-policy: 0 random, 1 round-robin |

## Verification
The bench fills the main array to exactly 32 entries while all four pinned slots are occupied. A design that let pinning consume main slots would then miss on a main page. Round-robin is checked by evicting twice and probing which pages survive. A pointer that moved during fills into free slots, or that started at a slot other than 0, leaves the wrong page resident.

Pinned-over-main priority is checked with the same page held in both groups under different frames. Address-based dropping is checked inside a 1 MB page at an offset far from the tag, where a compare at 4 KB granularity would keep the entry. Each flush command is followed by lookups in both groups, because a flush that cleared the wrong group shows up as a miss on a surviving entry. Lookups and commands issued while a walk is pending must leave no trace.

// File: rtl/xlt_pkg.sv
// Shared geometry, entry layout and page-match helpers for the translation cache.
// Assumes 32-bit virtual and physical addresses, 4 KB small and 1 MB large pages.
package xlt_pkg;
    localparam int VA_W      = 32;
    localparam int PG_SHIFT  = 12;
    localparam int BIG_SHIFT = 20;
    localparam int TAG_W     = VA_W - PG_SHIFT;
    localparam int BIG_TAG_W = VA_W - BIG_SHIFT;
    localparam int DOM_W     = 4;
    localparam int PERM_W    = 3;

    typedef struct packed {
        logic              vld;
        logic              big;
        logic [TAG_W-1:0]  tag;
        logic [TAG_W-1:0]  frame;
        logic [DOM_W-1:0]  dom;
        logic [PERM_W-1:0] perm;
    } xlt_entry_t;

    typedef enum logic [2:0] {
        OP_INV_MAIN = 3'd0,
        OP_INV_LOCK = 3'd1,
        OP_INV_VA   = 3'd2,
        OP_LOCK     = 3'd3,
        OP_SET_MODE = 3'd4
    } mc_op_e;

    typedef enum logic {
        REPL_RAND = 1'b0,
        REPL_RR   = 1'b1
    } repl_mode_e;

    // True when a valid entry's page contains the address.
    function automatic logic covers(xlt_entry_t e, logic [VA_W-1:0] va);
        if (!e.vld) return 1'b0;
        if (e.big) return e.tag[TAG_W-1 -: BIG_TAG_W] == va[VA_W-1 -: BIG_TAG_W];
        return e.tag == va[VA_W-1:PG_SHIFT];
    endfunction

    // Physical address formed from an entry and the untranslated offset.
    function automatic logic [VA_W-1:0] xlate(xlt_entry_t e, logic [VA_W-1:0] va);
        if (e.big) return {e.frame[TAG_W-1 -: BIG_TAG_W], va[BIG_SHIFT-1:0]};
        return {e.frame, va[PG_SHIFT-1:0]};
    endfunction
endpackage

// File: rtl/xlt_lfsr.sv
// Free-running Fibonacci LFSR, advancing every cycle.
// Assumes W in 2..10 so that a maximal-length tap mask is known; seeded to 1.
module xlt_lfsr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    function automatic logic [15:0] tap_mask(int w);
        case (w)
            2:       return 16'h0003;
            3:       return 16'h0006;
            4:       return 16'h000C;
            5:       return 16'h0014;
            6:       return 16'h0030;
            7:       return 16'h0060;
            8:       return 16'h00B8;
            9:       return 16'h0110;
            10:      return 16'h0240;
            default: return 16'h0014;
        endcase
    endfunction

    localparam logic [15:0]  TAP16 = tap_mask(W);
    localparam logic [W-1:0] TAPS  = TAP16[W-1:0];

    // Shift in the parity of the tapped bits each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= W'(1);
        else        state <= {state[W-2:0], ^(state & TAPS)};
    end
endmodule

// File: rtl/xlt_match.sv
// Parallel page compare over a group of entries; reports any hit and the
// lowest-index hitting entry. Assumes the group holds at most one cover per page.
module xlt_match
    import xlt_pkg::*;
#(
    parameter int N = 4
) (
    input  xlt_entry_t [N-1:0] ents,
    input  logic [VA_W-1:0]    va,
    output logic               hit,
    output xlt_entry_t         ent
);
    logic [N-1:0] hv;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hv[g] = covers(ents[g], va);
    end

    // Select the lowest-index hitting entry.
    always_comb begin
        ent = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hv[i]) ent = ents[i];
        end
    end

    assign hit = |hv;
endmodule

// File: rtl/xlt_victim.sv
// Main-array victim choice: lowest free slot first, otherwise round-robin
// pointer or LFSR value. Assumes N is a power of two.
module xlt_victim
    import xlt_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  repl_mode_e           mode,
    input  logic [N-1:0]         vld,
    input  logic                 commit,
    output logic [$clog2(N)-1:0] victim
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] rnd;
    logic [IW-1:0] rr_ptr;
    logic [IW-1:0] free_idx;
    logic          has_free;

    xlt_lfsr #(.W(IW)) i_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (rnd)
    );

    // Find the lowest-index invalid slot.
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                has_free = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    // Pick the victim from the free slot or the active policy.
    always_comb begin
        if (has_free)            victim = free_idx;
        else if (mode == REPL_RR) victim = rr_ptr;
        else                      victim = rnd;
    end

    // Advance the round-robin pointer only on round-robin evictions.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     rr_ptr <= '0;
        else if (commit && !has_free && mode == REPL_RR) rr_ptr <= rr_ptr + 1'b1;
    end
endmodule

// File: rtl/xlt_cache.sv
// Fully associative translation cache with a pinned area beside the main array.
// A lookup that misses raises a walk; the response fills a main or pinned slot.
// While a walk is outstanding, all lookups and commands are dropped.
// Assumes the walker answers every request exactly once.
module xlt_cache
    import xlt_pkg::*;
#(
    parameter int MAIN_N = 32,
    parameter int LOCK_N = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lk_valid,
    input  logic [31:0]               lk_va,
    output logic                      lk_rsp_valid,
    output logic                      lk_hit,
    output logic                      lk_locked,
    output logic [31:0]               lk_pa,
    output logic [3:0]                lk_domain,
    output logic [2:0]                lk_perm,
    output logic                      busy,
    output logic                      wk_req,
    output logic [31:0]               wk_va,
    input  logic                      wk_rsp_valid,
    input  logic                      wk_rsp_big,
    input  logic [19:0]               wk_rsp_frame,
    input  logic [3:0]                wk_rsp_domain,
    input  logic [2:0]                wk_rsp_perm,
    input  logic                      mc_valid,
    input  logic [2:0]                mc_op,
    input  logic [31:0]               mc_va,
    input  logic [$clog2(LOCK_N)-1:0] mc_slot,
    input  logic                      mc_mode
);
    localparam int MIDX_W = $clog2(MAIN_N);
    localparam int LIDX_W = $clog2(LOCK_N);

    xlt_entry_t [MAIN_N-1:0] main_q;
    xlt_entry_t [LOCK_N-1:0] lock_q;
    logic [MAIN_N-1:0]       main_vld;
    logic                    waiting;
    logic                    pend_lock;
    logic [LIDX_W-1:0]       pend_slot;
    repl_mode_e              repl_mode;
    logic                    main_hit_any;
    logic                    lock_hit_any;
    xlt_entry_t              main_ent;
    xlt_entry_t              lock_ent;
    xlt_entry_t              sel_ent;
    xlt_entry_t              new_ent;
    logic [MIDX_W-1:0]       victim;
    logic                    lk_fire;
    logic                    mc_fire;
    logic                    install;
    mc_op_e                  op;

    assign op      = mc_op_e'(mc_op);
    assign mc_fire = mc_valid && !waiting;
    assign lk_fire = lk_valid && !waiting && !mc_valid;
    assign install = waiting && wk_rsp_valid;
    assign busy    = waiting;
    assign wk_req  = waiting;

    for (genvar g = 0; g < MAIN_N; g++) begin : g_vld
        assign main_vld[g] = main_q[g].vld;
    end

    xlt_match #(.N(MAIN_N)) i_match_main (
        .ents (main_q),
        .va   (lk_va),
        .hit  (main_hit_any),
        .ent  (main_ent)
    );

    xlt_match #(.N(LOCK_N)) i_match_lock (
        .ents (lock_q),
        .va   (lk_va),
        .hit  (lock_hit_any),
        .ent  (lock_ent)
    );

    xlt_victim #(.N(MAIN_N)) i_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (repl_mode),
        .vld    (main_vld),
        .commit (install && !pend_lock),
        .victim (victim)
    );

    // Pinned hits take precedence over main hits.
    assign sel_ent = lock_hit_any ? lock_ent : main_ent;

    // Build the entry to install from the walk response.
    always_comb begin
        new_ent       = '0;
        new_ent.vld   = 1'b1;
        new_ent.big   = wk_rsp_big;
        new_ent.tag   = wk_va[VA_W-1:PG_SHIFT];
        new_ent.frame = wk_rsp_frame;
        new_ent.dom   = wk_rsp_domain;
        new_ent.perm  = wk_rsp_perm;
    end

    // Main array: flushes, drops by address, and fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAIN_N; i++) main_q[i] <= '0;
        end else begin
            if (mc_fire && op == OP_INV_MAIN) begin
                for (int i = 0; i < MAIN_N; i++) main_q[i].vld <= 1'b0;
            end
            if (mc_fire && op == OP_INV_VA) begin
                for (int i = 0; i < MAIN_N; i++) begin
                    if (covers(main_q[i], mc_va)) main_q[i].vld <= 1'b0;
                end
            end
            if (install && !pend_lock) main_q[victim] <= new_ent;
        end
    end

    // Pinned area: flush, drop by address, and pin fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LOCK_N; i++) lock_q[i] <= '0;
        end else begin
            if (mc_fire && op == OP_INV_LOCK) begin
                for (int i = 0; i < LOCK_N; i++) lock_q[i].vld <= 1'b0;
            end
            if (mc_fire && op == OP_INV_VA) begin
                for (int i = 0; i < LOCK_N; i++) begin
                    if (covers(lock_q[i], mc_va)) lock_q[i].vld <= 1'b0;
                end
            end
            if (install && pend_lock) lock_q[pend_slot] <= new_ent;
        end
    end

    // Walk control: start on a miss or a pin command, finish on a response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting   <= 1'b0;
            pend_lock <= 1'b0;
            pend_slot <= '0;
            wk_va     <= '0;
        end else if (install) begin
            waiting   <= 1'b0;
            pend_lock <= 1'b0;
        end else if (mc_fire && op == OP_LOCK) begin
            waiting   <= 1'b1;
            pend_lock <= 1'b1;
            pend_slot <= mc_slot;
            wk_va     <= mc_va;
        end else if (lk_fire && !lock_hit_any && !main_hit_any) begin
            waiting   <= 1'b1;
            pend_lock <= 1'b0;
            wk_va     <= lk_va;
        end
    end

    // Replacement policy register, pseudo-random out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                           repl_mode <= REPL_RAND;
        else if (mc_fire && op == OP_SET_MODE) repl_mode <= repl_mode_e'(mc_mode);
    end

    // Registered lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rsp_valid <= 1'b0;
            lk_hit       <= 1'b0;
            lk_locked    <= 1'b0;
            lk_pa        <= '0;
            lk_domain    <= '0;
            lk_perm      <= '0;
        end else begin
            lk_rsp_valid <= lk_fire;
            lk_hit       <= lk_fire && (lock_hit_any || main_hit_any);
            lk_locked    <= lk_fire && lock_hit_any;
            if (lk_fire && (lock_hit_any || main_hit_any)) begin
                lk_pa     <= xlate(sel_ent, lk_va);
                lk_domain <= sel_ent.dom;
                lk_perm   <= sel_ent.perm;
            end else if (lk_fire) begin
                lk_pa     <= '0;
                lk_domain <= '0;
                lk_perm   <= '0;
            end
        end
    end
endmodule

// File: rtl/xlt_cache_chk.sv
// Protocol and priority properties for the translation cache, bound to its top.
module xlt_cache_chk
    import xlt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        lk_fire,
    input logic        lock_hit_any,
    input logic        lk_rsp_valid,
    input logic        lk_hit,
    input logic        lk_locked,
    input logic        busy,
    input logic        wk_req,
    input logic [31:0] wk_va,
    input logic        wk_rsp_valid,
    input repl_mode_e  repl_mode
);
    AST_MODE_AT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> repl_mode == REPL_RAND); // R4

    AST_MISS_RAISES_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rsp_valid && !lk_hit |-> wk_req && busy); // R2

    AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wk_req && !wk_rsp_valid |=> wk_req && $stable(wk_va)); // R2

    AST_SILENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> !lk_rsp_valid); // R2

    AST_FILL_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        wk_req && wk_rsp_valid |=> !busy); // R3

    AST_PINNED_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fire && lock_hit_any |=> lk_hit && lk_locked); // R8

    AST_PINNED_FLAG_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_locked |-> lk_hit && lk_rsp_valid); // R7
endmodule

bind xlt_cache xlt_cache_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_fire      (lk_fire),
    .lock_hit_any (lock_hit_any),
    .lk_rsp_valid (lk_rsp_valid),
    .lk_hit       (lk_hit),
    .lk_locked    (lk_locked),
    .busy         (busy),
    .wk_req       (wk_req),
    .wk_va        (wk_va),
    .wk_rsp_valid (wk_rsp_valid),
    .repl_mode    (repl_mode)
);

// File: tb/test_xlt_cache.sv
`timescale 1ns/1ps
module test_xlt_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_rsp_valid, lk_hit, lk_locked, busy, wk_req;
    logic [31:0] lk_pa, wk_va;
    logic [3:0]  lk_domain;
    logic [2:0]  lk_perm;
    logic        wk_rsp_valid = 1'b0;
    logic        wk_rsp_big = 1'b0;
    logic [19:0] wk_rsp_frame = '0;
    logic [3:0]  wk_rsp_domain = '0;
    logic [2:0]  wk_rsp_perm = '0;
    logic        mc_valid = 1'b0;
    logic [2:0]  mc_op = '0;
    logic [31:0] mc_va = '0;
    logic [1:0]  mc_slot = '0;
    logic        mc_mode = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    xlt_cache i_xlt_cache (
        .clk, .rst_n, .lk_valid, .lk_va, .lk_rsp_valid, .lk_hit, .lk_locked,
        .lk_pa, .lk_domain, .lk_perm, .busy, .wk_req, .wk_va, .wk_rsp_valid,
        .wk_rsp_big, .wk_rsp_frame, .wk_rsp_domain, .wk_rsp_perm,
        .mc_valid, .mc_op, .mc_va, .mc_slot, .mc_mode
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Lookup; result sampled at the negedge after the accepting edge.
    task automatic lookup(input logic [31:0] va, output bit hit, output bit pinned, output logic [31:0] pa);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va;
        @(negedge clk);
        lk_valid = 1'b0;
        hit = lk_hit; pinned = lk_locked; pa = lk_pa;
    endtask

    task automatic serve(input bit big, input logic [19:0] frame, input logic [3:0] dom, input logic [2:0] perm);
        int n = 0;
        while (!wk_req && n < 20) begin @(negedge clk); n++; end
        wk_rsp_valid = 1'b1; wk_rsp_big = big; wk_rsp_frame = frame;
        wk_rsp_domain = dom; wk_rsp_perm = perm;
        @(negedge clk);
        wk_rsp_valid = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] op, input logic [31:0] va, input logic [1:0] slot, input bit mode);
        @(negedge clk);
        mc_valid = 1'b1; mc_op = op; mc_va = va; mc_slot = slot; mc_mode = mode;
        @(negedge clk);
        mc_valid = 1'b0;
    endtask

    function automatic logic [19:0] frm(input logic [31:0] va);
        return va[31:12] ^ 20'h5A5A5;
    endfunction

    // Lookup expecting a miss, then answer the walk with a 4 KB page.
    task automatic fill_small(input logic [31:0] va, input string req);
        bit h, p; logic [31:0] pa;
        lookup(va, h, p, pa);
        chk(!h && busy, req, {31'd0, h}, 32'd0);
        serve(1'b0, frm(va), 4'h3, 3'b101);
    endtask

    task automatic expect_hit(input logic [31:0] va, input logic [31:0] exp_pa, input bit exp_pin, input string req);
        bit h, p; logic [31:0] pa;
        lookup(va, h, p, pa);
        chk(h && p == exp_pin && pa == exp_pa, req, pa, exp_pa);
    endtask

    task automatic expect_miss(input logic [31:0] va, input string req);
        bit h, p; logic [31:0] pa;
        lookup(va, h, p, pa);
        chk(!h, req, {31'd0, h}, 32'd0);
        serve(1'b0, frm(va), 4'h3, 3'b101);
    endtask

    task automatic t_reset();
        bit h, p; logic [31:0] pa;
        repeat (3) @(negedge clk);
        chk(!lk_rsp_valid && !busy && !wk_req, "R4 idle outputs", {29'd0, lk_rsp_valid, busy, wk_req}, 32'd0);
        rst_n = 1'b1;
        lookup(32'h1234_5678, h, p, pa);
        chk(!h && lk_rsp_valid, "R4 empty after reset", {31'd0, h}, 32'd0);
        serve(1'b0, 20'hABCDE, 4'h7, 3'b011);
    endtask

    task automatic t_translate();
        bit h, p; logic [31:0] pa;
        lookup(32'h1234_5678, h, p, pa);
        chk(h && pa == 32'hABCD_E678, "R1 small page pa", pa, 32'hABCD_E678);
        chk(lk_domain == 4'h7 && lk_perm == 3'b011, "R1 domain/perm", {25'd0, lk_domain, lk_perm}, {25'd0, 4'h7, 3'b011});
        lookup(32'h4000_0000, h, p, pa);
        serve(1'b1, 20'h80100, 4'h2, 3'b110);
        lookup(32'h400A_BCDE, h, p, pa);
        chk(h && !p && pa == 32'h801A_BCDE, "R1 R3 large page pa", pa, 32'h801A_BCDE);
    endtask

    task automatic t_miss_wait();
        bit h, p; logic [31:0] pa;
        lookup(32'h5555_5123, h, p, pa);
        chk(wk_req && busy && wk_va == 32'h5555_5123, "R2 walk address", wk_va, 32'h5555_5123);
        @(negedge clk); lk_valid = 1'b1; lk_va = 32'h1234_5000;
        @(negedge clk); lk_valid = 1'b0;
        chk(!lk_rsp_valid && wk_va == 32'h5555_5123, "R2 lookup dropped while busy", {31'd0, lk_rsp_valid}, 32'd0);
        @(negedge clk); mc_valid = 1'b1; mc_op = 3'd0;
        @(negedge clk); mc_valid = 1'b0;
        chk(wk_req, "R2 walk request held", {31'd0, wk_req}, 32'd1);
        serve(1'b0, 20'h00555, 4'h1, 3'b001);
        chk(!busy, "R3 busy clears after fill", {31'd0, busy}, 32'd0);
        expect_hit(32'h1234_5001, 32'hABCD_E001, 1'b0, "R2 command dropped while busy");
        expect_hit(32'h5555_5FFF, 32'h0055_5FFF, 1'b0, "R3 filled page resident");
    endtask

    task automatic t_pin();
        bit h, p; logic [31:0] pa;
        cmd(3'd3, 32'h1234_5000, 2'd1, 1'b0);
        chk(wk_req && wk_va == 32'h1234_5000, "R7 pin requests walk", wk_va, 32'h1234_5000);
        serve(1'b0, 20'h11111, 4'h9, 3'b111);
        expect_hit(32'h1234_5678, 32'h1111_1678, 1'b1, "R8 pinned beats main");
        cmd(3'd3, 32'h0AA0_0000, 2'd0, 1'b0);
        serve(1'b1, 20'h0AA00, 4'hF, 3'b100);
        expect_hit(32'h0AA1_2345, 32'h0AA1_2345, 1'b1, "R7 pinned large page");
        // Command and lookup in the same cycle: the command wins.
        @(negedge clk);
        lk_valid = 1'b1; lk_va = 32'h1234_5678; mc_valid = 1'b1; mc_op = 3'd4; mc_mode = 1'b0;
        @(negedge clk);
        lk_valid = 1'b0; mc_valid = 1'b0;
        chk(!lk_rsp_valid, "R12 lookup dropped under command", {31'd0, lk_rsp_valid}, 32'd0);
    endtask

    task automatic t_invalidate();
        cmd(3'd0, 32'h0, 2'd0, 1'b0);
        expect_miss(32'h5555_5000, "R9 main flushed");
        expect_hit(32'h0AA1_2345, 32'h0AA1_2345, 1'b1, "R9 pinned kept");
        cmd(3'd2, 32'h0AAF_FFFF, 2'd0, 1'b0);
        expect_hit(32'h5555_5000, {frm(32'h5555_5000), 12'h000}, 1'b0, "R11 other entry kept");
        fill_small(32'h0AA1_2345, "R11 large pinned page dropped");
        cmd(3'd2, 32'h5555_5ABC, 2'd0, 1'b0);
        expect_miss(32'h5555_5000, "R11 main page dropped");
        cmd(3'd1, 32'h0, 2'd0, 1'b0);
        expect_hit(32'h5555_5004, {frm(32'h5555_5000), 12'h004}, 1'b0, "R10 main kept");
        expect_miss(32'h1234_5678, "R10 pinned flushed");
    endtask

    task automatic t_round_robin();
        cmd(3'd0, 32'h0, 2'd0, 1'b0);
        cmd(3'd1, 32'h0, 2'd0, 1'b0);
        cmd(3'd4, 32'h0, 2'd0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            cmd(3'd3, 32'h7000_0000 + (i << 12), 2'(i), 1'b0);
            serve(1'b0, 20'h70000 + 20'(i), 4'h0, 3'b001);
        end
        for (int i = 0; i < 32; i++) fill_small(32'h2000_0000 + (i << 12), "R3 fill main");
        for (int i = 0; i < 32; i++)
            expect_hit(32'h2000_0000 + (i << 12), {frm(32'h2000_0000 + (i << 12)), 12'h0}, 1'b0, "R7 all main slots usable");
        for (int i = 0; i < 4; i++)
            expect_hit(32'h7000_0010 + (i << 12), {20'h70000 + 20'(i), 12'h010}, 1'b1, "R7 pinned alongside full main");
        fill_small(32'h2002_0000, "R5 first eviction");
        fill_small(32'h2002_1000, "R5 second eviction");
        expect_hit(32'h2000_2000, {frm(32'h2000_2000), 12'h0}, 1'b0, "R5 slot 2 kept");
        expect_hit(32'h2002_1000, {frm(32'h2002_1000), 12'h0}, 1'b0, "R5 new page resident");
        expect_miss(32'h2000_0000, "R5 slot 0 evicted first");
        expect_miss(32'h2000_1000, "R5 slot 1 evicted second");
    endtask

    task automatic t_random();
        int misses = 0;
        bit h, p; logic [31:0] pa;
        cmd(3'd4, 32'h0, 2'd0, 1'b0);
        fill_small(32'h3000_0000, "R6 miss in random mode");
        expect_hit(32'h3000_0000, {frm(32'h3000_0000), 12'h0}, 1'b0, "R6 R12 new page resident");
        for (int i = 5; i < 32; i++) begin
            lookup(32'h2000_0000 + (i << 12), h, p, pa);
            if (!h) begin misses++; serve(1'b0, frm(32'h2000_0000 + (i << 12)), 4'h3, 3'b101); end
        end
        lookup(32'h2002_0000, h, p, pa);
        if (!h) begin misses++; serve(1'b0, frm(32'h2002_0000), 4'h3, 3'b101); end
        lookup(32'h2002_1000, h, p, pa);
        if (!h) begin misses++; serve(1'b0, frm(32'h2002_1000), 4'h3, 3'b101); end
        chk(misses >= 1, "R6 random eviction occurred", 32'(misses), 32'd1);
        for (int i = 0; i < 4; i++)
            expect_hit(32'h7000_0000 + (i << 12), {20'h70000 + 20'(i), 12'h0}, 1'b1, "R6 pinned survive random");
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        t_reset();
        t_translate();
        t_miss_wait();
        t_pin();
        t_invalidate();
        t_round_robin();
        t_random();
        repeat (2) @(negedge clk);
        report();
    end
endmodule